// File: doc/BRIEF.md
# Chained Serial Converter Frame Reader

This block is the host side of a chain of identical 16-bit serial converters. The converters are wired in daisy-chain fashion: the host drives the conversion-start line and the serial clock to every device, drives the serial input of the first device, and listens to the serial output of the last one. One frame starts a conversion in every device at once, waits out the conversion time, and then clocks the whole chain as one 16×NDEV-bit stream.

A frame is requested by a one-cycle start pulse or, when the automatic mode input is high, by an internal rate timer. The block keeps the chain-mode select line low at every conversion-start edge and keeps the serial clock low around that edge and through the conversion wait. It samples the returning data on serial-clock rising edges and splits the frame into per-device words. The results wait in a valid/ready output register until the host accepts them. Any request that arrives while a frame is in flight or unaccepted is discarded and reported with a one-cycle flag.

Serial-clock half period, conversion wait, minimum conversion spacing, timer period and chain length are all parameters counted in system clocks.

Top module: `chain_adc_reader`

## Requirements
- R1: While reset is active and right after it is released, `cnv_o`, `sck_o`, `sdi_o`, `res_valid_o` and `start_drop_o` are all low.
- R2: `sdi_o` is low at every rising edge of `cnv_o`, so that every device selects chain mode.
- R3: `sck_o` is low when `cnv_o` rises and makes no transition for at least CONV_WAIT clock cycles after that rise.
- R4: Each frame produces exactly 16×NDEV rising edges on `sck_o`. `cnv_o` stays high from before the first of them until after the last falling edge. `sck_o` never changes while `cnv_o` is low.
- R5: Once shifting starts, every low phase and every high phase of `sck_o` lasts exactly SCK_HALF clock cycles.
- R6: The returning data is sampled when `sck_o` rises, most significant bit first. The device whose serial input is `sdi_o` is device 0. Its word appears in `res_data_o[15:0]`, and device k appears in `res_data_o[16k+15:16k]`.
- R7: Two rising edges of `cnv_o` are never closer than CNV_GAP cycles. A request that is accepted earlier raises `cnv_o` exactly CNV_GAP cycles after the previous rise.
- R8: `res_valid_o` rises when a frame completes. It stays high with `res_data_o` unchanged until a cycle with `res_ready_i` high, and falls on the next clock edge.
- R9: A start pulse or timer request that arrives after a frame has been accepted and before its result has been taken does not start a frame. It raises `start_drop_o` for exactly the following cycle.
- R10: While `auto_en_i` is high, the internal timer requests a frame every RATE_CYC cycles. When the block is idle each time, consecutive `cnv_o` rises are exactly RATE_CYC cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle frame request |
| auto_en_i | input | 1 | Enables periodic requests from the internal timer |
| cnv_o | output | 1 | Conversion start to all devices, held high during readout |
| sck_o | output | 1 | Serial clock to all devices |
| sdi_o | output | 1 | Serial input of device 0, held low |
| sdo_i | input | 1 | Serial output of the last device in the chain |
| res_valid_o | output | 1 | Frame result available |
| res_ready_i | input | 1 | Host accepts the result |
| res_data_o | output | 16×NDEV | Per-device words, device 0 in the low 16 bits |
| start_drop_o | output | 1 | One-cycle flag for a discarded request |

## Verification
The bench models the device chain itself: each device loads its sample on the conversion-start rise and shifts on falling serial-clock edges. Patterns such as all-ones, all-zeros, single set bits at word edges and alternating bits therefore expose three kinds of fault. A reader that reverses the word order returns the devices swapped. One that samples on the wrong edge returns words shifted by a bit. One that stops one clock short loses the last bit of device 0. The bench requests a new frame immediately after a result is taken, to show that a missing spacing guard raises the conversion start early. It also sends a second start mid-frame and checks that a controller that queued or restarted would show an extra conversion edge. Finally, it holds the ready input low for several cycles to expose a result register that changes or drops its valid flag too early.

// File: rtl/cadc_pkg.sv
package cadc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_CONV,
    ST_SHIFT,
    ST_FIN,
    ST_HOLD
  } seq_state_e;

endpackage

// File: rtl/cadc_rst_sync.sv
module cadc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/cadc_rate_timer.sv
module cadc_rate_timer #(
  parameter int RATE_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);

  localparam int CW = $clog2(RATE_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(RATE_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = en_i && (cnt_q == CNT_LAST);
    if (!en_i || tick_o) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  generate
    if (RATE_CYC > 1) begin : g_tick_chk
      // R10: requests are spaced, never back to back
      assert_tick_spaced_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/cadc_seq.sv
module cadc_seq
  import cadc_pkg::*;
#(
  parameter int NBITS     = 48,
  parameter int SCK_HALF  = 2,
  parameter int CONV_WAIT = 79,
  parameter int CNV_GAP   = 209
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic ack_i,
  output logic cnv_o,
  output logic sck_o,
  output logic sample_o,
  output logic done_o,
  output logic drop_o
);

  localparam int HW = $clog2(SCK_HALF + 1);
  localparam int WW = $clog2(CONV_WAIT + 1);
  localparam int BW = $clog2(NBITS + 1);
  localparam int GW = $clog2(CNV_GAP + 1);
  localparam logic [HW-1:0] HALF_LAST = HW'(SCK_HALF - 1);
  localparam logic [WW-1:0] WAIT_LAST = WW'(CONV_WAIT - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(NBITS - 1);
  localparam logic [GW-1:0] GAP_LOAD  = GW'(CNV_GAP - 1);

  seq_state_e    st_q, st_d;
  logic          cnv_q, cnv_d;
  logic          sck_q, sck_d;
  logic          drop_q, drop_d;
  logic [HW-1:0] half_q, half_d;
  logic [WW-1:0] wait_q, wait_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [GW-1:0] gap_q, gap_d;

  always_comb begin
    st_d     = st_q;
    cnv_d    = cnv_q;
    sck_d    = sck_q;
    half_d   = half_q;
    wait_d   = wait_q;
    bit_d    = bit_q;
    gap_d    = (gap_q != '0) ? gap_q - GW'(1) : gap_q;
    drop_d   = req_i && (st_q != ST_IDLE);
    sample_o = 1'b0;
    done_o   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_i) st_d = ST_ARM;
      end
      ST_ARM: begin
        if (gap_q == '0) begin
          cnv_d  = 1'b1;
          gap_d  = GAP_LOAD;
          wait_d = '0;
          st_d   = ST_CONV;
        end
      end
      ST_CONV: begin
        if (wait_q == WAIT_LAST) begin
          half_d = '0;
          bit_d  = '0;
          st_d   = ST_SHIFT;
        end else begin
          wait_d = wait_q + WW'(1);
        end
      end
      ST_SHIFT: begin
        if (half_q == HALF_LAST) begin
          half_d = '0;
          sck_d  = !sck_q;
          if (!sck_q) begin
            sample_o = 1'b1;
          end else if (bit_q == BIT_LAST) begin
            st_d = ST_FIN;
          end else begin
            bit_d = bit_q + BW'(1);
          end
        end else begin
          half_d = half_q + HW'(1);
        end
      end
      ST_FIN: begin
        cnv_d  = 1'b0;
        done_o = 1'b1;
        st_d   = ST_HOLD;
      end
      ST_HOLD: begin
        if (ack_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnv_q  <= 1'b0;
      sck_q  <= 1'b0;
      drop_q <= 1'b0;
      half_q <= '0;
      wait_q <= '0;
      bit_q  <= '0;
      gap_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnv_q  <= cnv_d;
      sck_q  <= sck_d;
      drop_q <= drop_d;
      half_q <= half_d;
      wait_q <= wait_d;
      bit_q  <= bit_d;
      gap_q  <= gap_d;
    end
  end

  assign cnv_o  = cnv_q;
  assign sck_o  = sck_q;
  assign drop_o = drop_q;

  // Checker-only counter: cycles since the last conversion start
  logic [GW-1:0] since_q;
  logic          seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (cnv_d && !cnv_q) begin
      since_q <= '0;
      seen_q  <= 1'b1;
    end else if (since_q != GW'(CNV_GAP)) begin
      since_q <= since_q + GW'(1);
    end
  end

  assert_gap_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_d && !cnv_q) |-> (!seen_q || since_q >= GAP_LOAD));

  assert_sck_quiet_at_cnv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_q) |-> !sck_q);

  assert_sck_only_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sck_q) |-> cnv_q);

  assert_drop_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drop_q |-> ($past(st_q) != ST_IDLE));

endmodule

// File: rtl/cadc_capture.sv
module cadc_capture #(
  parameter int NDEV   = 3,
  parameter int WORD_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sample_i,
  input  logic                   sdo_i,
  input  logic                   done_i,
  input  logic                   ready_i,
  output logic                   valid_o,
  output logic [NDEV*WORD_W-1:0] data_o
);

  localparam int TOT = NDEV * WORD_W;

  logic [TOT-1:0]                    cap_q, cap_d;
  logic [NDEV-1:0][WORD_W-1:0]       by_dev;
  logic [NDEV-1:0][WORD_W-1:0]       out_q, out_d;
  logic                              valid_q, valid_d;

  // Words arrive last device first; arrival slot a sits at the top of the
  // shift register after the frame, so device k comes from arrival NDEV-1-k.
  generate
    for (genvar k = 0; k < NDEV; k++) begin : g_word
      localparam int ARRIVAL = NDEV - 1 - k;
      localparam int POS     = (NDEV - 1 - ARRIVAL) * WORD_W;
      assign by_dev[k] = cap_q[POS +: WORD_W];
    end
  endgenerate

  always_comb begin
    cap_d   = sample_i ? {cap_q[TOT-2:0], sdo_i} : cap_q;
    out_d   = done_i ? by_dev : out_q;
    valid_d = valid_q;
    if (done_i) begin
      valid_d = 1'b1;
    end else if (valid_q && ready_i) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= '0;
      out_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      cap_q   <= cap_d;
      out_q   <= out_d;
      valid_q <= valid_d;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = out_q;

  assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready_i) |=> (valid_q && $stable(out_q)));

  assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |-> !valid_q);

endmodule

// File: rtl/chain_adc_reader.sv
module chain_adc_reader #(
  parameter int NDEV      = 3,
  parameter int WORD_W    = 16,
  parameter int SCK_HALF  = 2,
  parameter int CONV_WAIT = 79,
  parameter int CNV_GAP   = 209,
  parameter int RATE_CYC  = 1000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   auto_en_i,
  output logic                   cnv_o,
  output logic                   sck_o,
  output logic                   sdi_o,
  input  logic                   sdo_i,
  output logic                   res_valid_o,
  input  logic                   res_ready_i,
  output logic [NDEV*WORD_W-1:0] res_data_o,
  output logic                   start_drop_o
);

  localparam int NBITS = NDEV * WORD_W;

  logic rst_sync_n;
  logic tick;
  logic req;
  logic sample;
  logic done;
  logic ack;

  cadc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cadc_rate_timer #(.RATE_CYC(RATE_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en_i   (auto_en_i),
    .tick_o (tick)
  );

  assign req   = start_i | tick;
  assign ack   = res_valid_o & res_ready_i;
  assign sdi_o = 1'b0;

  cadc_seq #(
    .NBITS     (NBITS),
    .SCK_HALF  (SCK_HALF),
    .CONV_WAIT (CONV_WAIT),
    .CNV_GAP   (CNV_GAP)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req_i    (req),
    .ack_i    (ack),
    .cnv_o    (cnv_o),
    .sck_o    (sck_o),
    .sample_o (sample),
    .done_o   (done),
    .drop_o   (start_drop_o)
  );

  cadc_capture #(.NDEV(NDEV), .WORD_W(WORD_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sample_i (sample),
    .sdo_i    (sdo_i),
    .done_i   (done),
    .ready_i  (res_ready_i),
    .valid_o  (res_valid_o),
    .data_o   (res_data_o)
  );

endmodule

// File: tb/chain_adc_reader_bench.sv
module chain_adc_reader_bench;

  localparam int ND   = 3;
  localparam int WW   = 16;
  localparam int HALF = 2;
  localparam int CWT  = 10;
  localparam int GAP  = 300;
  localparam int RATE = 400;
  localparam int NV   = 5;

  localparam logic [ND*WW-1:0] VEC [0:NV-1] = '{
    48'hFFFF_0000_8001,
    48'h0000_0000_0000,
    48'hFFFF_FFFF_FFFF,
    48'hA5A5_5A5A_1234,
    48'h0001_8000_7FFE
  };
  localparam int RDY_DLY [0:NV-1] = '{0, 3, 0, 7, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic auto_en_i = 1'b0;
  logic res_ready_i = 1'b0;
  logic cnv_o, sck_o, sdi_o, sdo_i, res_valid_o, start_drop_o;
  logic [ND*WW-1:0] res_data_o;

  always #4 clk = !clk;

  chain_adc_reader #(
    .NDEV(ND), .WORD_W(WW), .SCK_HALF(HALF), .CONV_WAIT(CWT),
    .CNV_GAP(GAP), .RATE_CYC(RATE)
  ) u_chain_adc_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .auto_en_i(auto_en_i),
    .cnv_o(cnv_o), .sck_o(sck_o), .sdi_o(sdi_o), .sdo_i(sdo_i),
    .res_valid_o(res_valid_o), .res_ready_i(res_ready_i),
    .res_data_o(res_data_o), .start_drop_o(start_drop_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural device chain and protocol monitor, evaluated at falling clk
  logic [WW-1:0] samp   [ND];
  logic [WW-1:0] dev_sr [ND];
  assign sdo_i = dev_sr[ND-1][WW-1];

  int cyc = 0;
  int frames = 0;
  int drops = 0;
  int last_rise = 0;
  int last_gap = 0;
  bit have_rise = 1'b0;
  int rises = 0;
  int edge_cyc = 0;
  logic cnv_p = 1'b0;
  logic sck_p = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (start_drop_o) drops = drops + 1;
      if (cnv_o && !cnv_p) begin
        chk(sdi_o == 1'b0, "R2 select low at conversion start", sdi_o, 0);
        chk(sck_o == 1'b0, "R3 clock low at conversion start", sck_o, 0);
        if (have_rise) begin
          last_gap = cyc - last_rise;
          chk(last_gap >= GAP, "R7 conversion spacing", last_gap, GAP);
        end
        have_rise = 1'b1;
        last_rise = cyc;
        frames = frames + 1;
        rises = 0;
        for (int k = 0; k < ND; k++) dev_sr[k] = samp[k];
      end
      if (sck_o != sck_p) begin
        chk(cnv_o == 1'b1, "R4 clock moves only in frame", cnv_o, 1);
        if (sck_o && rises == 0) begin
          chk((cyc - last_rise) >= CWT, "R3 conversion wait", cyc - last_rise, CWT);
        end else begin
          chk((cyc - edge_cyc) == HALF, "R5 clock phase length", cyc - edge_cyc, HALF);
        end
        edge_cyc = cyc;
        if (sck_o) rises = rises + 1;
        else begin
          for (int k = ND - 1; k > 0; k--) dev_sr[k] = {dev_sr[k][WW-2:0], dev_sr[k-1][WW-1]};
          dev_sr[0] = {dev_sr[0][WW-2:0], sdi_o};
        end
      end
      if (!cnv_o && cnv_p) begin
        chk(rises == ND * WW, "R4 clock count per frame", rises, ND * WW);
        chk(sck_o == 1'b0, "R4 clock low at frame end", sck_o, 0);
      end
      cnv_p = cnv_o;
      sck_p = sck_o;
    end
  end

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_valid();
    while (!res_valid_o) @(negedge clk);
  endtask

  task automatic take_result();
    res_ready_i = 1'b1;
    @(negedge clk);
    res_ready_i = 1'b0;
    chk(res_valid_o == 1'b0, "R8 valid clears after handshake", res_valid_o, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    logic [ND*WW-1:0] snap;
    int f0, d0;
    for (int k = 0; k < ND; k++) begin
      samp[k] = '0;
      dev_sr[k] = '0;
    end

    // R1: reset state
    repeat (5) @(negedge clk);
    chk({cnv_o, sck_o, sdi_o, res_valid_o, start_drop_o} == 5'b0,
        "R1 outputs in reset", {cnv_o, sck_o, sdi_o, res_valid_o, start_drop_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({cnv_o, sck_o, sdi_o, res_valid_o, start_drop_o} == 5'b0,
        "R1 outputs after release", {cnv_o, sck_o, sdi_o, res_valid_o, start_drop_o}, 0);

    // Vector table: frames back to back
    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < ND; k++) samp[k] = VEC[i][k*WW +: WW];
      pulse_start();
      wait_valid();
      snap = res_data_o;
      for (int d = 0; d < RDY_DLY[i]; d++) begin
        @(negedge clk);
        chk(res_valid_o == 1'b1, "R8 valid held without ready", res_valid_o, 1);
        chk(res_data_o == snap, "R8 data stable without ready", res_data_o, snap);
      end
      for (int k = 0; k < ND; k++) begin
        chk(res_data_o[k*WW +: WW] == VEC[i][k*WW +: WW], "R6 device word",
            res_data_o[k*WW +: WW], VEC[i][k*WW +: WW]);
      end
      take_result();
      if (i == 1) chk(last_gap == GAP, "R7 early request waits exact spacing", last_gap, GAP);
    end

    // R9: request during a frame is dropped and flagged
    f0 = frames;
    d0 = drops;
    samp[0] = 16'h0F0F; samp[1] = 16'h3C3C; samp[2] = 16'hC003;
    pulse_start();
    repeat (20) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(start_drop_o == 1'b1, "R9 drop flag raised", start_drop_o, 1);
    @(negedge clk);
    chk(start_drop_o == 1'b0, "R9 drop flag one cycle", start_drop_o, 0);
    wait_valid();
    chk(res_data_o == {16'hC003, 16'h3C3C, 16'h0F0F}, "R6 data after dropped request",
        res_data_o, {16'hC003, 16'h3C3C, 16'h0F0F});
    take_result();
    repeat (400) @(negedge clk);
    chk(frames - f0 == 1, "R9 no extra frame", frames - f0, 1);
    chk(drops - d0 == 1, "R9 one drop counted", drops - d0, 1);
    chk(cnv_o == 1'b0, "R9 chain idle after drop", cnv_o, 0);

    // R10: periodic requests
    f0 = frames;
    d0 = drops;
    res_ready_i = 1'b1;
    auto_en_i = 1'b1;
    repeat (3 * RATE + 50) @(negedge clk);
    auto_en_i = 1'b0;
    chk(frames - f0 == 3, "R10 timed frame count", frames - f0, 3);
    chk(last_gap == RATE, "R10 timed spacing", last_gap, RATE);
    chk(drops == d0, "R10 no drops in timed mode", drops - d0, 0);
    repeat (300) @(negedge clk);
    res_ready_i = 1'b0;
    chk(res_valid_o == 1'b0 && cnv_o == 1'b0, "R10 idle after timer off",
        {res_valid_o, cnv_o}, 0);

    finish_run();
  end

endmodule